// File: doc/BRIEF.md
# DMA Global Operation Register with Intermittent Transfer Pacing

This block is the global control and status word of a multi-channel DMA controller, together with the gate that paces transfer grants. Software reaches it through a simple register port. The word holds a mode field for cycle-steal transfers, a channel-priority field that is passed straight on to the channel arbiter, and a master enable. It also holds two sticky error flags, one for address errors and one for non-maskable interrupt events, which hardware sets.

The transfer engine raises a request, and the block answers with a registered grant. In normal mode every pending request is granted on the next clock. In the two intermittent modes, grants are spaced exactly 16 or 64 bus clocks apart. These modes apply only while every channel reports cycle-steal bus mode. In any other case the block runs as in normal mode. Grants stop entirely while the master enable is clear or either error flag is raised.

A flag clears only through a two-step handshake. Software first reads the register and sees the flag as 1. Its next write must then carry a 0 in that flag's position. Any write consumes the record of that read. If a hardware event and a clear hit the same flag in the same cycle, the hardware event wins.

Top module: `dma_opreg_pace`

## Requirements
- R1: After reset, a register read returns 0x0000, `xfer_gnt` is 0 and `prio_out` is 0.
- R2: Bits 15:14, 11:10 and 7:3 always read as 0, and writes to them have no effect.
- R3: A write stores bits 13:12 (mode), bits 9:8 (priority) and bit 0 (master enable). A read with `reg_rd` high returns the whole word on `reg_rdata` in the next cycle. `prio_out` always equals bits 9:8.
- R4: Normal pacing applies when the mode is 00, when the mode is 01 (a stored but prohibited code), or when any bit of `ch_cycle_steal` is 0. Under normal pacing, each cycle in which a request is held leads to `xfer_gnt` being high in the following cycle, so grants can come back to back.
- R5: When the mode is 10 and all `ch_cycle_steal` bits are 1, and the request is held continuously, consecutive grants are exactly 16 clocks apart.
- R6: When the mode is 11 and all `ch_cycle_steal` bits are 1, and the request is held continuously, consecutive grants are exactly 64 clocks apart.
- R7: No grant is issued while `xfer_req` is 0, while bit 0 is 0, or while bit 2 or bit 1 is set.
- R8: A pulse on `addr_err_evt` sets bit 2, and a pulse on `nmi_evt` sets bit 1. Each flag is set in the next cycle and stays set. Writing 1 to either bit never sets it and never clears it.
- R9: A flag clears only on a write with 0 in its bit, and only if the most recent register access before that write was a read that returned the flag as 1. A write without such a read leaves the flag unchanged, and so does a second write after that read.
- R10: When a flag's hardware event and a valid clear of that flag come in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data, valid the cycle after `reg_rd` |
| ch_cycle_steal | input | NUM_CH | Per-channel flag: channel is in cycle-steal bus mode |
| addr_err_evt | input | 1 | Address error event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| xfer_req | input | 1 | Transfer request from the engine |
| xfer_gnt | output | 1 | Registered transfer grant |
| prio_out | output | 2 | Channel priority field toward the arbiter |

## Verification
A corrupted pacing counter shows up on `xfer_gnt` at the next pair of grants: the gap between them comes out other than 1, 16 or 64. With a steady request this takes at most 64 clocks. A wrong flag, enable or read-arm state appears either as a grant where none should come, or as a wrong bit 2 or bit 1 on the first read after the faulty write. The bench therefore sweeps every mode against every cycle-steal pattern, measuring each grant gap. It also steps the flag handshake through each of its orderings, reading the register back after each step.

// File: rtl/dma_opreg_pkg.sv
package dma_opreg_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    CSM_NORMAL = 2'b00,
    CSM_RSVD   = 2'b01,
    CSM_INT16  = 2'b10,
    CSM_INT64  = 2'b11
  } csm_e;

  localparam int MODE_LSB = 12;
  localparam int PRIO_LSB = 8;
  localparam int AE_BIT   = 2;
  localparam int NMI_BIT  = 1;
  localparam int EN_BIT   = 0;
endpackage

// File: rtl/dma_opreg_regs.sv
module dma_opreg_regs
  import dma_opreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             addr_err_evt,
  input  logic             nmi_evt,
  output logic [REG_W-1:0] reg_rdata,
  output csm_e             mode,
  output logic [1:0]       prio,
  output logic             dma_en,
  output logic             ae_flag,
  output logic             nmi_flag
);
  logic ae_arm, nmi_arm;
  logic ae_clr, nmi_clr;
  logic [REG_W-1:0] word;

  assign ae_clr  = reg_wr && ae_arm  && !reg_wdata[AE_BIT];
  assign nmi_clr = reg_wr && nmi_arm && !reg_wdata[NMI_BIT];

  always_comb begin
    word = '0;
    word[MODE_LSB +: 2] = mode;
    word[PRIO_LSB +: 2] = prio;
    word[AE_BIT]  = ae_flag;
    word[NMI_BIT] = nmi_flag;
    word[EN_BIT]  = dma_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= CSM_NORMAL;
      prio      <= '0;
      dma_en    <= 1'b0;
      ae_flag   <= 1'b0;
      nmi_flag  <= 1'b0;
      ae_arm    <= 1'b0;
      nmi_arm   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        mode    <= csm_e'(reg_wdata[MODE_LSB +: 2]);
        prio    <= reg_wdata[PRIO_LSB +: 2];
        dma_en  <= reg_wdata[EN_BIT];
        ae_arm  <= 1'b0;
        nmi_arm <= 1'b0;
      end else if (reg_rd) begin
        ae_arm  <= ae_flag;
        nmi_arm <= nmi_flag;
      end
      if (reg_rd) reg_rdata <= word;
      ae_flag  <= addr_err_evt || (ae_flag  && !ae_clr);
      nmi_flag <= nmi_evt      || (nmi_flag && !nmi_clr);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[15:14] == 2'b00) && (reg_rdata[11:10] == 2'b00) && (reg_rdata[7:3] == 5'd0)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(addr_err_evt && !rst) |-> ae_flag); // R10

  AST_AE_CLEAR_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(ae_flag) |-> $past(reg_wr && ae_arm && !reg_wdata[AE_BIT])); // R9

  AST_NMI_CLEAR_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_flag) |-> $past(reg_wr && nmi_arm && !reg_wdata[NMI_BIT])); // R9
endmodule

// File: rtl/dma_opreg_pacer.sv
module dma_opreg_pacer
  import dma_opreg_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int INT_SHORT = 16,
  parameter int INT_LONG  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  csm_e              mode,
  input  logic [NUM_CH-1:0] ch_cycle_steal,
  input  logic              grant_ok,
  input  logic              xfer_req,
  output logic              xfer_gnt
);
  localparam int CNT_W = $clog2(INT_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(INT_LONG);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(INT_SHORT);

  logic             all_cs;
  logic             paced;
  logic [CNT_W-1:0] intv;
  logic [CNT_W-1:0] since_q;
  logic             issue;

  assign all_cs = &ch_cycle_steal;

  always_comb begin
    paced = 1'b0;
    intv  = CNT_W'(1);
    if (all_cs) begin
      case (mode)
        CSM_INT16: begin paced = 1'b1; intv = CNT_SHORT; end
        CSM_INT64: begin paced = 1'b1; intv = CNT_MAX;   end
        default:   begin paced = 1'b0; intv = CNT_W'(1); end
      endcase
    end
  end

  assign issue = grant_ok && xfer_req && (!paced || (since_q >= intv));

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q  <= CNT_MAX;
      xfer_gnt <= 1'b0;
    end else begin
      xfer_gnt <= issue;
      if (issue)                 since_q <= CNT_W'(1);
      else if (since_q < CNT_MAX) since_q <= since_q + CNT_W'(1);
    end
  end

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    xfer_gnt |-> $past(xfer_req && grant_ok)); // R7

  AST_BACK2BACK_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (xfer_gnt && $past(xfer_gnt)) |-> $past(!paced)); // R4
endmodule

// File: rtl/dma_opreg_pace.sv
module dma_opreg_pace
  import dma_opreg_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int INT_SHORT = 16,
  parameter int INT_LONG  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ch_cycle_steal,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic              xfer_req,
  output logic              xfer_gnt,
  output logic [1:0]        prio_out
);
  csm_e mode;
  logic dma_en, ae_flag, nmi_flag, grant_ok;

  dma_opreg_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_wdata    (reg_wdata),
    .addr_err_evt (addr_err_evt),
    .nmi_evt      (nmi_evt),
    .reg_rdata    (reg_rdata),
    .mode         (mode),
    .prio         (prio_out),
    .dma_en       (dma_en),
    .ae_flag      (ae_flag),
    .nmi_flag     (nmi_flag)
  );

  assign grant_ok = dma_en && !ae_flag && !nmi_flag;

  dma_opreg_pacer #(
    .NUM_CH    (NUM_CH),
    .INT_SHORT (INT_SHORT),
    .INT_LONG  (INT_LONG)
  ) u_pacer (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .ch_cycle_steal (ch_cycle_steal),
    .grant_ok       (grant_ok),
    .xfer_req       (xfer_req),
    .xfer_gnt       (xfer_gnt)
  );

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    xfer_gnt |-> $past(dma_en && !ae_flag && !nmi_flag)); // R7
endmodule

// File: tb/dma_opreg_pace_tb_top.sv
module dma_opreg_pace_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NCH-1:0] ch_cs = '0;
  logic ae_evt = 1'b0, nmi_ev = 1'b0, req = 1'b0;
  logic gnt;
  logic [1:0] prio;

  int vectors = 0;
  int errors  = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_opreg_pace #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_cycle_steal(ch_cs),
    .addr_err_evt(ae_evt), .nmi_evt(nmi_ev), .xfer_req(req),
    .xfer_gnt(gnt), .prio_out(prio)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v, input logic ae_same = 1'b0);
    reg_wr = 1'b1; reg_wdata = v; ae_evt = ae_same;
    @(negedge clk);
    reg_wr = 1'b0; ae_evt = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold request for n cycles, count grants and check each gap
  task automatic pace_run(input int n, input int exp_gap, input string tag);
    int last, cnt, bad, badgap;
    last = -1; cnt = 0; bad = 0; badgap = 0;
    req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt) begin
        if (last >= 0 && (i - last) != exp_gap && bad == 0) begin
          bad = 1; badgap = i - last;
        end
        last = i; cnt++;
      end
    end
    req = 1'b0;
    check({tag, " gap"}, bad ? badgap : exp_gap, exp_gap);
    check({tag, " grants>=2"}, int'(cnt >= 2), 1);
    idle(2);
  endtask

  task automatic no_grant_run(input int n, input string tag);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt) cnt++;
    end
    check(tag, cnt, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 gnt", int'(gnt), 0);
    check("R1 prio", int'(prio), 0);
    rd(v);
    check("R1 read", int'(v), 16'h0000);

    // R2/R3/R8 all ones written: reserved stay 0, flags not set by write
    wr(16'hFFFF);
    rd(v);
    check("R2 R8 write all ones", int'(v), 16'h3301);

    // R2 R3 sweep all writable field combinations with reserved bits toggled
    for (int k = 0; k < 64; k++) begin
      w = {2'b11 & 2'(k * 3), 2'(k >> 4), 2'b10, 2'(k >> 2), 5'h15, 1'b1, 1'b1, 1'(k)};
      wr(w);
      check("R3 prio_out", int'(prio), int'(w[9:8]));
      rd(v);
      check("R2 R3 readback", int'(v), int'({2'b00, w[13:12], 2'b00, w[9:8], 5'd0, 2'b00, w[0]}));
    end

    // R7 request absent
    wr(16'h0001);
    no_grant_run(80, "R7 no request");

    // R4 R5 R6 sweep modes against cycle-steal patterns
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 16; p++) begin
        ch_cs = 4'(p);
        wr(16'((m << 12) | 1));
        if (p == 15 && m == 2)      gap = 16;
        else if (p == 15 && m == 3) gap = 64;
        else                        gap = 1;
        if (gap == 16)      pace_run(100, 16, "R5 int16");
        else if (gap == 64) pace_run(280, 64, "R6 int64");
        else                pace_run(20, 1, "R4 normal");
      end
    end

    // R7 enable clear under continuous request
    ch_cs = 4'hF;
    wr(16'h0000);
    req = 1'b1;
    no_grant_run(80, "R7 enable off");
    req = 1'b0;

    // R8 R9 address error flag handshake
    wr(16'h0001);
    @(negedge clk);
    ae_evt = 1'b1; @(negedge clk); ae_evt = 1'b0;
    req = 1'b1;
    no_grant_run(20, "R7 ae flag blocks");
    req = 1'b0;
    wr(16'h0001);                      // not armed since the flag rose
    rd(v);
    check("R9 unarmed write keeps ae", int'(v), 16'h0005);
    wr(16'h0005);                      // armed but writes 1: no clear, consumes
    wr(16'h0001);                      // arm consumed: no clear
    rd(v);
    check("R8 R9 ae sticky", int'(v), 16'h0005);
    wr(16'h0001);                      // armed by previous read: clears
    rd(v);
    check("R9 ae cleared", int'(v), 16'h0001);
    pace_run(20, 1, "R9 grants resume");

    // R10 set wins over clear
    ae_evt = 1'b1; @(negedge clk); ae_evt = 1'b0;
    rd(v);
    check("R8 ae set", int'(v), 16'h0005);
    wr(16'h0001, 1'b1);
    rd(v);
    check("R10 set wins", int'(v), 16'h0005);
    wr(16'h0001);
    rd(v);
    check("R9 ae cleared after set-wins", int'(v), 16'h0001);

    // R8 R9 NMI flag
    nmi_ev = 1'b1; @(negedge clk); nmi_ev = 1'b0;
    req = 1'b1;
    no_grant_run(20, "R7 nmi flag blocks");
    req = 1'b0;
    wr(16'h0001);
    rd(v);
    check("R9 nmi unarmed", int'(v), 16'h0003);
    wr(16'h0003);
    rd(v);
    check("R8 nmi write one keeps", int'(v), 16'h0003);
    wr(16'h0001);
    rd(v);
    check("R9 nmi cleared", int'(v), 16'h0001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule